// File: doc/BRIEF.md
# Transmit Holding-Empty Status and Interrupt Generator

This block produces the "holding register empty" status bit and the matching transmit interrupt for a UART that has a 16-entry transmit FIFO. It reads the FIFO occupancy, the CPU's writes to the holding register, its reads of the interrupt identification register, a single-cycle strobe that marks a toggle of the FIFO-enable control bit, a bit-rate tick, and the current frame geometry. The FIFO storage and the transmit shifter are outside the block.

The status bit usually rises once the FIFO drains. After a lone byte has passed through, the rise is held back by one character time minus the final stop bit. This delay is counted in bit-rate ticks and is sized as the frame length minus the stop-bit count. If at least two bytes sat in the FIFO together since the last rise, the status bit rises at once. The block keeps a pending transmit interrupt and masks it with the two enables. It also resolves the identification code for the whole port: line status ranks first, receive data and receive timeout share the next level, then transmit empty, and lastly "none".

Top module: `thre_irq_gen`

## Requirements
- R1: While reset is asserted, and on its release, `thre` is 1, `tx_irq` is 0 and `irq_id` is 4'b0001 (no interrupt).
- R2: A cycle with `thr_wr` high makes `thre` 0 and `tx_irq` 0 at the next clock edge.
- R3: Suppose `tx_count` has reached 2 or more since `thre` last rose. When the FIFO is then empty (`tx_count`==0, no `thr_wr`), `thre` rises at the next edge. Each rise clears this history.
- R4: Otherwise the first empty cycle starts a delay of L = `frame_bits` − `stop_bits` ticks, with a minimum of 1. `thre` rises at the edge that samples the L-th `baud_tick` after that cycle.
- R5: A `thr_wr` or a nonzero `tx_count` during the delay cancels it. The next emptying starts a full new delay.
- R6: The transmit interrupt is enabled only when `fifo_en` and `txint_en` are both 1. A rise of `thre` while it is disabled leaves nothing pending. Clearing either enable masks `tx_irq` in the same cycle.
- R7: A rise of `thre` while the interrupt is enabled makes `tx_irq` 1 at that same edge, with `irq_id` 4'b0010.
- R8: A `fen_chg` strobe while the interrupt is enabled (using the new `fifo_en`), with `thre` 1 and no `thr_wr`, makes `tx_irq` 1 at the next edge.
- R9: An `iid_rd` clears the pending transmit interrupt at the next edge only if `irq_id` shows 4'b0010 in that cycle. Otherwise the interrupt stays pending.
- R10: `irq_id` is combinational, with this priority: `ls_pend` gives 4'b0110. Otherwise `rx_pend` gives 4'b0100. Otherwise `tmo_pend` gives 4'b1100. Otherwise `tx_irq` gives 4'b0010. Otherwise the code is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO-enable control bit |
| txint_en | input | 1 | Transmit interrupt enable bit |
| fen_chg | input | 1 | One-cycle strobe: FIFO-enable bit just changed |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | CPU write strobe to the holding register |
| iid_rd | input | 1 | CPU read strobe of the identification register |
| baud_tick | input | 1 | One pulse per serial bit time |
| frame_bits | input | 4 | Bits per character including start, parity and stop |
| stop_bits | input | 2 | Stop bits in the frame |
| ls_pend | input | 1 | Line-status interrupt pending |
| rx_pend | input | 1 | Receive-data interrupt pending |
| tmo_pend | input | 1 | Receive-timeout interrupt pending |
| thre | output | 1 | Holding register empty status |
| tx_irq | output | 1 | Transmit-empty interrupt request |
| irq_id | output | 4 | Identification code of the highest pending source |

## Verification
The drain path runs under three occupancy histories: a single byte, a FIFO that reached two bytes, and a single byte whose delay is cut by a new write. Comparing these separates the immediate rise from the delayed rise, and shows whether the delay restarts or resumes after a cancel. The delay is measured at three frame geometries, including one where the stop bits exceed the frame, so that an off-by-one tick count or a missing clamp shows up as an early or late rise. All eight combinations of the higher-priority sources are applied over a pending transmit interrupt. Identification reads are issued both while a higher source hides the transmit code and while the transmit code is shown.

// File: rtl/thre_irq_pkg.sv
package thre_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_TXEMPTY = 4'b0010,
        IID_RXDATA  = 4'b0100,
        IID_LINE    = 4'b0110,
        IID_RXTMO   = 4'b1100
    } iid_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic rxtmo;
        logic txempty;
    } irq_src_t;

    // Bits of a character that precede the final stop bits; never below one.
    function automatic logic [7:0] gap_bits(input logic [7:0] frame, input logic [7:0] stops);
        if (frame > stops) return frame - stops;
        return 8'd1;
    endfunction

endpackage

// File: rtl/thre_gap_timer.sv
module thre_gap_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done
);
    logic [LEN_W-1:0] cnt_q;
    logic             busy_q;

    assign busy = busy_q;
    assign done = busy_q && !abort && tick && (cnt_q <= LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= len;
        end else if (busy_q && tick) begin
            if (cnt_q <= LEN_W'(1)) busy_q <= 1'b0;
            else                    cnt_q  <= cnt_q - LEN_W'(1);
        end
    end
endmodule

// File: rtl/thre_tracker.sv
module thre_tracker
    import thre_irq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int LEN_W  = 4,
    parameter int STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              thr_wr,
    input  logic              tick,
    input  logic [LEN_W-1:0]  frame_bits,
    input  logic [STOP_W-1:0] stop_bits,
    output logic              thre,
    output logic              thre_rise
);
    logic             thre_q;
    logic             seen2_q;
    logic             empty;
    logic             t_busy;
    logic             t_done;
    logic             t_start;
    logic             fire_now;
    logic [LEN_W-1:0] gap_len;

    assign gap_len  = LEN_W'(gap_bits(8'(frame_bits), 8'(stop_bits)));
    assign empty    = (tx_count == '0) && !thr_wr;
    assign fire_now = empty && !thre_q && seen2_q;
    assign t_start  = empty && !thre_q && !seen2_q && !t_busy;
    assign thre_rise = fire_now || t_done;
    assign thre     = thre_q;

    thre_gap_timer #(.LEN_W(LEN_W)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .start(t_start),
        .abort(!empty),
        .tick (tick),
        .len  (gap_len),
        .busy (t_busy),
        .done (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thre_q  <= 1'b1;
            seen2_q <= 1'b0;
        end else begin
            if (!empty)         thre_q <= 1'b0;
            else if (thre_rise) thre_q <= 1'b1;

            if (thre_rise)                       seen2_q <= 1'b0;
            else if (tx_count >= CNT_W'(2))      seen2_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tx_irq_pend.sv
module tx_irq_pend (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic thre,
    input  logic thre_rise,
    input  logic thr_wr,
    input  logic fen_chg,
    input  logic iid_rd,
    input  logic tx_shown,
    output logic pend
);
    logic set_c;
    logic clr_c;

    assign set_c = en && (thre_rise || (fen_chg && thre));
    assign clr_c = iid_rd && tx_shown;

    always_ff @(posedge clk) begin
        if (rst)         pend <= 1'b0;
        else if (thr_wr) pend <= 1'b0;
        else if (set_c)  pend <= 1'b1;
        else if (clr_c)  pend <= 1'b0;
    end
endmodule

// File: rtl/iid_prio.sv
module iid_prio
    import thre_irq_pkg::*;
(
    input  irq_src_t   src,
    output logic [3:0] iid,
    output logic       tx_shown
);
    iid_e code;

    always_comb begin
        if (src.line)         code = IID_LINE;
        else if (src.rxdata)  code = IID_RXDATA;
        else if (src.rxtmo)   code = IID_RXTMO;
        else if (src.txempty) code = IID_TXEMPTY;
        else                  code = IID_NONE;
    end

    assign iid      = code;
    assign tx_shown = (code == IID_TXEMPTY);
endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen
    import thre_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FRAME_W    = 4,
    parameter int STOP_W     = 2,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_en,
    input  logic               txint_en,
    input  logic               fen_chg,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               thr_wr,
    input  logic               iid_rd,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic [STOP_W-1:0]  stop_bits,
    input  logic               ls_pend,
    input  logic               rx_pend,
    input  logic               tmo_pend,
    output logic               thre,
    output logic               tx_irq,
    output logic [3:0]         irq_id
);
    logic     en;
    logic     rise;
    logic     pend;
    logic     shown;
    irq_src_t src;

    assign en = fifo_en && txint_en;

    thre_tracker #(.CNT_W(CNT_W), .LEN_W(FRAME_W), .STOP_W(STOP_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .tx_count  (tx_count),
        .thr_wr    (thr_wr),
        .tick      (baud_tick),
        .frame_bits(frame_bits),
        .stop_bits (stop_bits),
        .thre      (thre),
        .thre_rise (rise)
    );

    tx_irq_pend u_pend (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .thre     (thre),
        .thre_rise(rise),
        .thr_wr   (thr_wr),
        .fen_chg  (fen_chg),
        .iid_rd   (iid_rd),
        .tx_shown (shown),
        .pend     (pend)
    );

    assign tx_irq = pend && en;
    assign src    = '{line: ls_pend, rxdata: rx_pend, rxtmo: tmo_pend, txempty: tx_irq};

    iid_prio u_prio (
        .src     (src),
        .iid     (irq_id),
        .tx_shown(shown)
    );
endmodule

// File: rtl/thre_irq_chk.sv
module thre_irq_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             txint_en,
    input logic             fen_chg,
    input logic [CNT_W-1:0] tx_count,
    input logic             thr_wr,
    input logic             iid_rd,
    input logic             ls_pend,
    input logic             thre,
    input logic             tx_irq,
    input logic [3:0]       irq_id
);
    p_wr_clears_r2: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> (!thre && !tx_irq));

    p_rise_when_empty_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(thre) |-> ($past(tx_count) == '0 && !$past(thr_wr)));

    p_fast_after_two_r3: assert property (@(posedge clk) disable iff (rst)
        (!thre && tx_count == '0 && !thr_wr && $past(tx_count) >= CNT_W'(2)) |=> thre);

    p_fen_immediate_r8: assert property (@(posedge clk) disable iff (rst)
        (fen_chg && fifo_en && txint_en && thre && !thr_wr) |=> (tx_irq || !(fifo_en && txint_en)));

    p_rise_raises_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(thre) && fifo_en && txint_en && $past(fifo_en && txint_en)) |-> tx_irq);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (iid_rd && irq_id == 4'b0010 && thre && !fen_chg) |=> !tx_irq);

    p_line_first_r10: assert property (@(posedge clk) disable iff (rst)
        ls_pend |-> (irq_id == 4'b0110));
endmodule

bind thre_irq_gen thre_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fifo_en (fifo_en),
    .txint_en(txint_en),
    .fen_chg (fen_chg),
    .tx_count(tx_count),
    .thr_wr  (thr_wr),
    .iid_rd  (iid_rd),
    .ls_pend (ls_pend),
    .thre    (thre),
    .tx_irq  (tx_irq),
    .irq_id  (irq_id)
);

// File: tb/sim_thre_irq_gen.sv
module sim_thre_irq_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en, txint_en, fen_chg, thr_wr, iid_rd, baud_tick;
    logic [4:0] tx_count;
    logic [3:0] frame_bits;
    logic [1:0] stop_bits;
    logic       ls_pend, rx_pend, tmo_pend;
    logic       thre, tx_irq;
    logic [3:0] irq_id;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    thre_irq_gen u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .txint_en(txint_en), .fen_chg(fen_chg),
        .tx_count(tx_count), .thr_wr(thr_wr), .iid_rd(iid_rd), .baud_tick(baud_tick),
        .frame_bits(frame_bits), .stop_bits(stop_bits), .ls_pend(ls_pend),
        .rx_pend(rx_pend), .tmo_pend(tmo_pend), .thre(thre), .tx_irq(tx_irq), .irq_id(irq_id)
    );

    // {ls, rx, tmo, expected id} with a transmit interrupt pending
    localparam logic [6:0] PRI_TBL [8] = '{
        {3'b000, 4'b0010}, {3'b001, 4'b1100}, {3'b010, 4'b0100}, {3'b011, 4'b0100},
        {3'b100, 4'b0110}, {3'b101, 4'b0110}, {3'b110, 4'b0110}, {3'b111, 4'b0110}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1;
            step();
            baud_tick = 1'b0;
            step();
        end
    endtask

    task automatic write_byte();
        thr_wr = 1'b1;
        step();
        thr_wr = 1'b0;
    endtask

    task automatic pulse_fen();
        fen_chg = 1'b1;
        step();
        fen_chg = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 1'b0; txint_en = 1'b0; fen_chg = 1'b0; thr_wr = 1'b0;
        iid_rd = 1'b0; baud_tick = 1'b0; tx_count = '0; frame_bits = 4'd10; stop_bits = 2'd1;
        ls_pend = 1'b0; rx_pend = 1'b0; tmo_pend = 1'b0;
        #1;
        step(); step(); step();
        chk("R1 thre in reset", 8'(thre), 8'd1);
        rst = 1'b0;
        chk("R1 thre", 8'(thre), 8'd1);
        chk("R1 tx_irq", 8'(tx_irq), 8'd0);
        chk("R1 irq_id", 8'(irq_id), 8'h01);

        // enables alone do not raise anything
        fifo_en = 1'b1; txint_en = 1'b1;
        step();
        chk("R6 no pending from enable", 8'(tx_irq), 8'd0);
        pulse_fen();
        chk("R8 fen change raises", 8'(tx_irq), 8'd1);
        chk("R7 code tx", 8'(irq_id), 8'h02);

        // priority table (R10)
        for (int i = 0; i < 8; i++) begin
            {ls_pend, rx_pend, tmo_pend} = PRI_TBL[i][6:4];
            #1;
            chk("R10 priority", 8'(irq_id), 8'(PRI_TBL[i][3:0]));
        end
        {ls_pend, rx_pend, tmo_pend} = 3'b000;

        // R9: read while hidden keeps, read while shown clears
        ls_pend = 1'b1; iid_rd = 1'b1;
        step();
        iid_rd = 1'b0; ls_pend = 1'b0;
        #1;
        chk("R9 hidden read keeps", 8'(tx_irq), 8'd1);
        iid_rd = 1'b1;
        step();
        iid_rd = 1'b0;
        chk("R9 shown read clears", 8'(tx_irq), 8'd0);

        // R2 write clears
        pulse_fen();
        chk("R8 re-raise", 8'(tx_irq), 8'd1);
        write_byte();
        chk("R2 thre cleared", 8'(thre), 8'd0);
        chk("R2 irq cleared", 8'(tx_irq), 8'd0);

        // R4 single byte delay L=9
        tx_count = 5'd1; step(); step();
        tx_count = 5'd0; step();
        ticks(8);
        chk("R4 still busy at 8 ticks", 8'(thre), 8'd0);
        ticks(1);
        chk("R4 rise at 9th tick", 8'(thre), 8'd1);
        chk("R7 irq on rise", 8'(tx_irq), 8'd1);

        // R3 two bytes held
        write_byte();
        tx_count = 5'd2; step();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        chk("R3 immediate rise", 8'(thre), 8'd1);
        chk("R3 irq", 8'(tx_irq), 8'd1);
        write_byte();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        chk("R3 history cleared", 8'(thre), 8'd0);
        ticks(9);
        chk("R4 after history", 8'(thre), 8'd1);

        // R5 cancel and restart
        write_byte();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        ticks(5);
        write_byte();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        ticks(8);
        chk("R5 full restart", 8'(thre), 8'd0);
        ticks(1);
        chk("R5 rise after restart", 8'(thre), 8'd1);

        // R4 two stop bits: L=10
        frame_bits = 4'd12; stop_bits = 2'd2;
        write_byte();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        ticks(9);
        chk("R4 two stops early", 8'(thre), 8'd0);
        ticks(1);
        chk("R4 two stops rise", 8'(thre), 8'd1);

        // R4 clamp: L=1
        frame_bits = 4'd1; stop_bits = 2'd2;
        write_byte();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        step();
        chk("R4 clamp no tick", 8'(thre), 8'd0);
        ticks(1);
        chk("R4 clamp one tick", 8'(thre), 8'd1);
        frame_bits = 4'd10; stop_bits = 2'd1;

        // R6 disabled rise leaves nothing pending; mask
        txint_en = 1'b0;
        write_byte();
        tx_count = 5'd2; step();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        chk("R6 thre rises", 8'(thre), 8'd1);
        chk("R6 no irq disabled", 8'(tx_irq), 8'd0);
        txint_en = 1'b1;
        step();
        chk("R6 nothing pending", 8'(tx_irq), 8'd0);
        pulse_fen();
        chk("R8 after enable", 8'(tx_irq), 8'd1);
        fifo_en = 1'b0;
        #1;
        chk("R6 masked", 8'(tx_irq), 8'd0);
        fifo_en = 1'b1;
        #1;
        chk("R6 unmasked", 8'(tx_irq), 8'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule